// File: doc/BRIEF.md
# Low-Power Retention Entry and Restart-Origin Controller

This block governs the clock-stopped, memory-retaining sleep state of a small 4-bit processor core. It watches the instruction-decode strobes for a two-instruction arming sequence. When an arming instruction is followed immediately, as the very next executed instruction, by a power-off instruction, it stops the oscillator and holds the port levels. It pulses a set of per-domain clear enables. These enables decide which architectural state is initialized on the way into sleep and which is kept.

On the way out it requests a restart at address 0 of page 0. It keeps a sticky power-down flag that software tests to tell the two restart kinds apart. A restart caused by the wakeup input from sleep is warm and sets the flag. Any of the reset pin, a watchdog reset, a low-voltage reset or a software reset instruction causes a cold restart and clears the flag. The block also decides how the shared counter/port pin behaves during sleep, and whether the low-voltage detector stays armed while the clock is stopped.

Top module: `pdc_ctrl`

## Requirements
- R1: An executed arming instruction followed, as the next executed instruction, by an executed power-off instruction raises `osc_stop_o` and `port_hold_o` in the cycle after the power-off strobe. Cycles with `ins_valid_i` low do not count as instructions.
- R2: A power-off instruction does nothing when the previous executed instruction was not the arming instruction. Any other executed instruction, or any cold reset, between the two cancels the arming.
- R3: With `osc_stop_o` high, `wake_i` leaves sleep in the next cycle, pulses `restart_o` for one cycle and sets `pdflag_o` to 1. `pdflag_o` stays 1 until a cold reset. `wake_i` outside sleep has no effect.
- R4: Each cold source (`rst_n` low, `wdt_rst_i`, `lvd_rst_i`, `sw_rst_i`) gives, in the next cycle, `restart_o` = 1, `pdflag_o` = 0 and `osc_stop_o` = 0.
- R5: A cold source in the same cycle as a wakeup or a power-off entry wins: the flag is cleared and sleep is not entered or kept.
- R6: On entry, `clr_o` (bit n = domain n) is 15'h7827 for exactly the first sleep cycle. Bits 0 (PC/A/B/carry), 1 (stack pointer to 7), 2 (group-1 interrupt control), 5 (clock control), 11 (external interrupt flags), 12 (ADC done flag), 13 (interrupt enable) and 14 (watchdog flags/enable) are set. Bits 3, 4, 6, 7, 8, 9 and 10 (group-2 interrupt control, oscillator select, timer control, ADC control, key wakeup, pull-ups, port direction) stay 0.
- R7: `clr_o` is all ones in the cycle after a cold source and while `rst_n` is low. A warm wakeup clears no domain (`clr_o` = 0).
- R8: In sleep with `cntr_mode_i` = 2'b11, `cntr_hiz_o` = 1 and `cntr_drive_low_o` = 0. In sleep with any other mode, `cntr_drive_low_o` = 1 and `cntr_hiz_o` = 0. Outside sleep both are 0.
- R9: `lvd_keep_o` is 1 in sleep only when the last executed detector-enable instruction ran while `lvd_pin_en_i` was high. A cold reset forgets it.
- R10: While in sleep, instruction strobes are ignored, and sleep persists until a wakeup or a cold source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Reset pin, synchronous active low, a cold source |
| ins_valid_i | input | 1 | An instruction executes this cycle |
| ins_arm_i | input | 1 | Executing instruction is the arming instruction |
| ins_pwroff_i | input | 1 | Executing instruction is the power-off instruction |
| ins_lvd_en_i | input | 1 | Executing instruction is the detector-enable instruction |
| lvd_pin_en_i | input | 1 | External detector-enable pin level |
| wake_i | input | 1 | External wakeup |
| wdt_rst_i | input | 1 | Watchdog reset request |
| lvd_rst_i | input | 1 | Low-voltage reset request |
| sw_rst_i | input | 1 | Software reset instruction strobe |
| cntr_mode_i | input | 2 | Counter/port pin mode field |
| osc_stop_o | output | 1 | Oscillator stop, high in sleep |
| port_hold_o | output | 1 | Hold port output levels |
| restart_o | output | 1 | Restart at address 0, page 0 |
| pdflag_o | output | 1 | Power-down flag (1 = last restart warm) |
| clr_o | output | 15 | Per-domain clear enables |
| cntr_drive_low_o | output | 1 | Force counter/port pin low |
| cntr_hiz_o | output | 1 | Release counter/port pin to high impedance |
| lvd_keep_o | output | 1 | Keep low-voltage detector active in sleep |

## Verification
The hardest cases are the collisions: a cold source landing in the very cycle of a power-off entry or a wakeup, and an arming that is broken by an intervening instruction or reset. Idle cycles with no executed instruction must not break it. The stimulus builds these from single-cycle instruction recipes placed back to back. Arm, idle gap and power-off follow each other, and power-off is combined with a software reset in one cycle. Wakeup and watchdog reset arrive together while asleep. A behavioural model tracks arming, sleep, flag and detector state and is compared on every clock.

// File: rtl/pdc_pkg.sv
// Shared definitions for the retention controller: the state domains whose
// clear enables the block drives, and which of them are initialized on entry.
package pdc_pkg;

    typedef enum int unsigned {
        DOM_CORE      = 0,  // PC, accumulator, B, carry
        DOM_STACKPTR  = 1,  // stack pointer, loaded with 7
        DOM_IRQ_GRP1  = 2,
        DOM_IRQ_GRP2  = 3,
        DOM_OSC_SEL   = 4,
        DOM_CLK_CTL   = 5,
        DOM_TMR_CTL   = 6,
        DOM_ADC_CTL   = 7,
        DOM_KEY_WAKE  = 8,
        DOM_PULLUP    = 9,
        DOM_PORT_DIR  = 10,
        DOM_EXT_FLAGS = 11,
        DOM_ADC_DONE  = 12,
        DOM_INT_EN    = 13,
        DOM_WDT       = 14
    } pdc_dom_e;

    localparam int unsigned PDC_NDOM = 15;

    // True when a domain is initialized as sleep is entered.
    function automatic logic cleared_on_entry(input int unsigned d);
        case (d)
            DOM_CORE, DOM_STACKPTR, DOM_IRQ_GRP1, DOM_CLK_CTL,
            DOM_EXT_FLAGS, DOM_ADC_DONE, DOM_INT_EN, DOM_WDT: return 1'b1;
            default:                                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pdc_arm_seq.sv
// Arming sequencer: remembers whether the last executed instruction was the
// arming instruction and flags a valid power-off entry.
// Assumes at most one decode strobe is high per executed instruction.
module pdc_arm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_i,
    input  logic in_sleep_i,
    input  logic ins_valid_i,
    input  logic ins_arm_i,
    input  logic ins_pwroff_i,
    output logic enter_o
);
    logic armed_q;

    // Entry: power-off executes right after the arm, not asleep, no cold reset.
    assign enter_o = ins_valid_i & ins_pwroff_i & armed_q & ~in_sleep_i & ~cold_i;

    // Arm latch follows each executed instruction; idle cycles keep it.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_i) begin
            armed_q <= 1'b0;
        end else if (ins_valid_i && !in_sleep_i) begin
            armed_q <= ins_arm_i & ~ins_pwroff_i;
        end
    end
endmodule

// File: rtl/pdc_start_track.sv
// Sleep state, restart request and power-down flag.
// Assumes cold_i already excludes the reset pin, which acts through rst_n.
module pdc_start_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_i,
    input  logic enter_i,
    input  logic wake_i,
    output logic sleep_o,
    output logic restart_o,
    output logic pdflag_o
);
    logic sleep_q, restart_q, pd_q;
    logic wake_ok;

    assign wake_ok = sleep_q & wake_i;

    // Cold sources beat wakeup and entry; wakeup marks a warm start.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_i) begin
            sleep_q   <= 1'b0;
            pd_q      <= 1'b0;
            restart_q <= 1'b1;
        end else begin
            restart_q <= wake_ok;
            if (wake_ok) begin
                sleep_q <= 1'b0;
                pd_q    <= 1'b1;
            end else if (enter_i) begin
                sleep_q <= 1'b1;
            end
        end
    end

    assign sleep_o   = sleep_q;
    assign restart_o = restart_q;
    assign pdflag_o  = pd_q;
endmodule

// File: rtl/pdc_retain_ctl.sv
// Retain/clear control: per-domain clear pulses, detector keep latch and
// counter/port pin treatment during sleep.
// Assumes enter_i and cold_i are never both high (the sequencer ensures it).
module pdc_retain_ctl #(
    parameter int unsigned NDOM         = pdc_pkg::PDC_NDOM,
    parameter int unsigned CNTR_MODE_W  = 2,
    parameter logic [CNTR_MODE_W-1:0] CNTR_IN_CODE = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cold_i,
    input  logic                   enter_i,
    input  logic                   sleep_i,
    input  logic                   ins_valid_i,
    input  logic                   ins_lvd_en_i,
    input  logic                   lvd_pin_en_i,
    input  logic [CNTR_MODE_W-1:0] cntr_mode_i,
    output logic [NDOM-1:0]        clr_o,
    output logic                   cntr_drive_low_o,
    output logic                   cntr_hiz_o,
    output logic                   lvd_keep_o
);
    logic [NDOM-1:0] clr_q;
    logic            lvd_q;
    logic            cntr_is_input;

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        localparam logic ON_ENTRY = pdc_pkg::cleared_on_entry(g);
        // One-cycle clear for this domain on a cold reset or, if listed, on entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clr_q[g] <= 1'b1;
            end else begin
                clr_q[g] <= cold_i | (enter_i & ON_ENTRY);
            end
        end
    end

    // Detector keep latch: last enable instruction samples the external pin.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_i) begin
            lvd_q <= 1'b0;
        end else if (ins_valid_i && ins_lvd_en_i && !sleep_i) begin
            lvd_q <= lvd_pin_en_i;
        end
    end

    assign cntr_is_input    = (cntr_mode_i == CNTR_IN_CODE);
    assign cntr_drive_low_o = sleep_i & ~cntr_is_input;
    assign cntr_hiz_o       = sleep_i & cntr_is_input;
    assign lvd_keep_o       = sleep_i & lvd_q;
    assign clr_o            = clr_q;
endmodule

// File: rtl/pdc_ctrl.sv
// Top of the retention controller: merges cold sources and wires the
// arming sequencer, start tracker and retain/clear control together.
// Assumes all inputs are synchronous to clk.
module pdc_ctrl #(
    parameter int unsigned NDOM        = pdc_pkg::PDC_NDOM,
    parameter int unsigned CNTR_MODE_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ins_valid_i,
    input  logic                   ins_arm_i,
    input  logic                   ins_pwroff_i,
    input  logic                   ins_lvd_en_i,
    input  logic                   lvd_pin_en_i,
    input  logic                   wake_i,
    input  logic                   wdt_rst_i,
    input  logic                   lvd_rst_i,
    input  logic                   sw_rst_i,
    input  logic [CNTR_MODE_W-1:0] cntr_mode_i,
    output logic                   osc_stop_o,
    output logic                   port_hold_o,
    output logic                   restart_o,
    output logic                   pdflag_o,
    output logic [NDOM-1:0]        clr_o,
    output logic                   cntr_drive_low_o,
    output logic                   cntr_hiz_o,
    output logic                   lvd_keep_o
);
    logic cold, enter, sleep;

    assign cold = wdt_rst_i | lvd_rst_i | sw_rst_i;

    pdc_arm_seq u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cold_i      (cold),
        .in_sleep_i  (sleep),
        .ins_valid_i (ins_valid_i),
        .ins_arm_i   (ins_arm_i),
        .ins_pwroff_i(ins_pwroff_i),
        .enter_o     (enter)
    );

    pdc_start_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .cold_i   (cold),
        .enter_i  (enter),
        .wake_i   (wake_i),
        .sleep_o  (sleep),
        .restart_o(restart_o),
        .pdflag_o (pdflag_o)
    );

    pdc_retain_ctl #(
        .NDOM       (NDOM),
        .CNTR_MODE_W(CNTR_MODE_W)
    ) u_retain (
        .clk             (clk),
        .rst_n           (rst_n),
        .cold_i          (cold),
        .enter_i         (enter),
        .sleep_i         (sleep),
        .ins_valid_i     (ins_valid_i),
        .ins_lvd_en_i    (ins_lvd_en_i),
        .lvd_pin_en_i    (lvd_pin_en_i),
        .cntr_mode_i     (cntr_mode_i),
        .clr_o           (clr_o),
        .cntr_drive_low_o(cntr_drive_low_o),
        .cntr_hiz_o      (cntr_hiz_o),
        .lvd_keep_o      (lvd_keep_o)
    );

    assign osc_stop_o  = sleep;
    assign port_hold_o = sleep;
endmodule

// File: rtl/pdc_ctrl_chk.sv
// Property checker for pdc_ctrl, attached through bind; observes ports only.
module pdc_ctrl_chk #(
    parameter int unsigned NDOM        = pdc_pkg::PDC_NDOM,
    parameter int unsigned CNTR_MODE_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ins_valid_i,
    input logic                   ins_pwroff_i,
    input logic                   wake_i,
    input logic                   wdt_rst_i,
    input logic                   lvd_rst_i,
    input logic                   sw_rst_i,
    input logic [CNTR_MODE_W-1:0] cntr_mode_i,
    input logic                   osc_stop_o,
    input logic                   restart_o,
    input logic                   pdflag_o,
    input logic [NDOM-1:0]        clr_o,
    input logic                   cntr_drive_low_o,
    input logic                   cntr_hiz_o,
    input logic                   lvd_keep_o
);
    logic cold_src;
    logic [NDOM-1:0] entry_pat;
    assign cold_src = wdt_rst_i | lvd_rst_i | sw_rst_i;
    always_comb begin
        for (int i = 0; i < NDOM; i++) entry_pat[i] = pdc_pkg::cleared_on_entry(i);
    end

    p_entry_after_pwroff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stop_o) |-> $past(ins_valid_i && ins_pwroff_i));
    p_warm_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop_o && wake_i && !cold_src) |=> (pdflag_o && restart_o && !osc_stop_o));
    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdflag_o) |-> $past(osc_stop_o && wake_i));
    p_cold_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cold_src |=> (!pdflag_o && restart_o && !osc_stop_o));
    p_cold_beats_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop_o && wake_i && cold_src) |=> !pdflag_o);
    p_entry_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stop_o) |-> (clr_o == entry_pat));
    p_cold_clears_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cold_src |=> (&clr_o));
    p_pin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_stop_o |-> (!cntr_drive_low_o && !cntr_hiz_o));
    p_pin_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop_o && (&cntr_mode_i)) |-> (cntr_hiz_o && !cntr_drive_low_o));
    p_lvd_only_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_keep_o |-> osc_stop_o);
    p_sleep_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop_o && !wake_i && !cold_src) |=> osc_stop_o);
endmodule

bind pdc_ctrl pdc_ctrl_chk #(.NDOM(NDOM), .CNTR_MODE_W(CNTR_MODE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ins_valid_i     (ins_valid_i),
    .ins_pwroff_i    (ins_pwroff_i),
    .wake_i          (wake_i),
    .wdt_rst_i       (wdt_rst_i),
    .lvd_rst_i       (lvd_rst_i),
    .sw_rst_i        (sw_rst_i),
    .cntr_mode_i     (cntr_mode_i),
    .osc_stop_o      (osc_stop_o),
    .restart_o       (restart_o),
    .pdflag_o        (pdflag_o),
    .clr_o           (clr_o),
    .cntr_drive_low_o(cntr_drive_low_o),
    .cntr_hiz_o      (cntr_hiz_o),
    .lvd_keep_o      (lvd_keep_o)
);

// File: tb/pdc_ctrl_test.sv
// Bench: behavioural model compared with the design on every clock.
module pdc_ctrl_test;
    localparam int NDOM = 15;
    localparam logic [14:0] ENTRY_MASK = 15'h7827;
    localparam logic [14:0] ALL_MASK   = 15'h7FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid_i = 0, ins_arm_i = 0, ins_pwroff_i = 0, ins_lvd_en_i = 0;
    logic lvd_pin_en_i = 0, wake_i = 0, wdt_rst_i = 0, lvd_rst_i = 0, sw_rst_i = 0;
    logic [1:0] cntr_mode_i = 2'b00;
    logic osc_stop_o, port_hold_o, restart_o, pdflag_o;
    logic [NDOM-1:0] clr_o;
    logic cntr_drive_low_o, cntr_hiz_o, lvd_keep_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pdc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid_i), .ins_arm_i(ins_arm_i),
        .ins_pwroff_i(ins_pwroff_i), .ins_lvd_en_i(ins_lvd_en_i),
        .lvd_pin_en_i(lvd_pin_en_i), .wake_i(wake_i), .wdt_rst_i(wdt_rst_i),
        .lvd_rst_i(lvd_rst_i), .sw_rst_i(sw_rst_i), .cntr_mode_i(cntr_mode_i),
        .osc_stop_o(osc_stop_o), .port_hold_o(port_hold_o), .restart_o(restart_o),
        .pdflag_o(pdflag_o), .clr_o(clr_o), .cntr_drive_low_o(cntr_drive_low_o),
        .cntr_hiz_o(cntr_hiz_o), .lvd_keep_o(lvd_keep_o)
    );

    // Model state
    bit m_arm = 0, m_sleep = 0, m_pd = 0, m_lvd = 0, m_rs = 1;
    logic [14:0] m_clr = ALL_MASK;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance the model at each edge, then compare shortly after.
    always @(posedge clk) begin
        bit cold, woke, ent;
        cold = !rst_n || wdt_rst_i || lvd_rst_i || sw_rst_i;
        woke = m_sleep && wake_i;
        ent  = !m_sleep && ins_valid_i && ins_pwroff_i && m_arm;
        if (cold) begin
            m_arm = 0; m_sleep = 0; m_pd = 0; m_lvd = 0; m_rs = 1; m_clr = ALL_MASK;
        end else begin
            m_rs  = woke;
            m_clr = ent ? ENTRY_MASK : 15'h0;
            if (!m_sleep && ins_valid_i && ins_lvd_en_i) m_lvd = lvd_pin_en_i;
            if (woke) begin
                m_sleep = 0; m_pd = 1; m_arm = 0;
            end else if (ent) begin
                m_sleep = 1; m_arm = 0;
            end else if (!m_sleep && ins_valid_i) begin
                m_arm = ins_arm_i && !ins_pwroff_i;
            end
        end
        #2;
        if (!done) begin
            cmp("R1 R2 R10", "osc_stop", osc_stop_o, m_sleep);
            cmp("R1", "port_hold", port_hold_o, m_sleep);
            cmp("R3 R4", "restart", restart_o, m_rs);
            cmp("R3 R4 R5", "pdflag", pdflag_o, m_pd);
            cmp("R6 R7", "clr", clr_o, m_clr);
            cmp("R8", "drive_low", cntr_drive_low_o, m_sleep && cntr_mode_i != 2'b11);
            cmp("R8", "hiz", cntr_hiz_o, m_sleep && cntr_mode_i == 2'b11);
            cmp("R9", "lvd_keep", lvd_keep_o, m_sleep && m_lvd);
        end
    end

    // One cycle of stimulus. 0 idle,1 arm,2 pwroff,3 other instr,4 lvd enable,
    // 5 wake,6 wdt,7 lvd reset,8 sw reset,9 pin reset,10 wake+wdt,11 pwroff+sw reset
    task automatic op(input int k);
        @(negedge clk);
        ins_valid_i = 0; ins_arm_i = 0; ins_pwroff_i = 0; ins_lvd_en_i = 0;
        wake_i = 0; wdt_rst_i = 0; lvd_rst_i = 0; sw_rst_i = 0; rst_n = 1;
        case (k)
            1: begin ins_valid_i = 1; ins_arm_i = 1; end
            2: begin ins_valid_i = 1; ins_pwroff_i = 1; end
            3: ins_valid_i = 1;
            4: begin ins_valid_i = 1; ins_lvd_en_i = 1; end
            5: wake_i = 1;
            6: wdt_rst_i = 1;
            7: lvd_rst_i = 1;
            8: sw_rst_i = 1;
            9: rst_n = 0;
            10: begin wake_i = 1; wdt_rst_i = 1; end
            11: begin ins_valid_i = 1; ins_pwroff_i = 1; sw_rst_i = 1; end
            default: ;
        endcase
    endtask

    task automatic enter_sleep();
        op(1); op(2); op(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        op(0); op(0);
        op(2); op(0);                 // R2 lone power-off
        op(1); op(3); op(2); op(0);   // R2 broken arm
        op(1); op(9); op(2); op(0);   // R2 reset cancels arm
        cntr_mode_i = 2'b00;
        enter_sleep();                // R1, R6
        op(1); op(2); op(4); op(0);   // R10 strobes ignored
        cntr_mode_i = 2'b11; op(0);   // R8
        op(5); op(0); op(0);          // R3 warm
        op(5); op(0);                 // R3 wake outside sleep
        op(1); op(0); op(0); op(2); op(0);  // R1 idle gap keeps arm
        op(5); op(0);
        op(1); op(1); op(2); op(0);   // R1 repeated arm
        op(6); op(0);                 // R4 watchdog
        enter_sleep(); op(7); op(0);  // R4 low-voltage reset
        enter_sleep(); op(8); op(0);  // R4 software reset
        enter_sleep(); op(9); op(0);  // R4 pin reset
        enter_sleep(); op(10); op(0); // R5 wake + cold
        op(1); op(11); op(0); op(0);  // R5 entry + cold
        lvd_pin_en_i = 0; op(4); enter_sleep(); op(5);   // R9 pin low
        lvd_pin_en_i = 1; op(4); cntr_mode_i = 2'b01; enter_sleep(); op(0); op(5); // R9 pin high
        op(0); op(8); op(0); enter_sleep(); op(6); op(0);  // R9 cold forgets
        op(0); op(0);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule